// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block is a synthesizable model of the command side of a parallel NOR flash device. A host reaches it over a simple strobe bus: an active-low select, separate active-low write and read strobes, an address and a 16-bit data path. The block samples that bus on its own clock. Write strobes are not stored straight into the array. The block decodes them as multi-cycle unlock and command sequences. Those sequences start internally timed program or sector-erase operations on a small on-chip array.

While an operation runs, the ready output is low. A read at any address then returns a status word instead of array data. In that word, bit 7 is the inverse of bit 7 of the data being written, and bit 6 flips on each new read access. When the operation finishes, the block returns to array reads. A faster program path skips the two unlock writes once the host has entered a bypass mode. Sectors can be locked one by one, and a low-supply input blocks every write.

Top module: `flash_cmd_core`

## Requirements
- R1: After reset, ready is high and every word of the array reads 0xFFFF.
- R2: Four writes (0xAA to command address 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then data to the target) store the data. A later word-mode read of the target returns it.
- R3: Ready goes low on the clock edge that takes the last program write and stays low for exactly PROG_CYC clock cycles.
- R4: A read during an operation returns 0 in bits 15:8 and 5:0, the inverse of bit 7 of the pending data in bit 7, and a bit 6 that differs between two consecutive read accesses. Once the operation completes, reads return array data again.
- R5: In byte mode the command address is the bus address shifted right by one, and bus address bit 0 picks the high (1) or low (0) byte. Byte reads return that byte on bits 7:0 with bits 15:8 at zero. A byte program changes only the selected byte.
- R6: The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0x20 at 0x555 enters bypass mode. In bypass mode, 0xA0 followed by a data write programs that data, and any other single write is ignored. Writing 0x90 then 0x00 leaves bypass mode, after which a two-write program has no effect.
- R7: Writing 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at an address in the sector erases that sector. Ready stays low for sector-words plus ERASE_CYC cycles, the status bit 7 reads 0, and afterwards the sector reads 0xFFFF while other sectors keep their contents.
- R8: The erase first clears each word of the sector to zero, one word per cycle, and only then runs the timed erase pulse that sets the whole sector to ones.
- R9: A program or erase aimed at a sector whose lock bit is set starts nothing: ready stays high and the data is unchanged.
- R10: While supply_low is high, writes are ignored.
- R11: A write that does not fit the expected next step of a partial sequence (including 0xF0) drops the sequence and returns to read mode. The remaining steps written afterwards then have no effect.
- R12: Writes made while ready is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_n | input | 1 | Active-low device select |
| bus_wr_n | input | 1 | Active-low write strobe; falling edge takes a write |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_addr | input | ADDR_W | Word address, or byte address in byte mode |
| bus_wdata | input | 16 | Write data; commands use bits 7:0 |
| bus_rdata | output | 16 | Read data or status; zero when not reading |
| byte_mode | input | 1 | 1 selects 8-bit data access |
| supply_low | input | 1 | Blocks all writes while high |
| sect_lock | input | 2**SECT_W | One lock bit per sector |
| ready | output | 1 | Low while an operation runs |

## Verification
Most internal faults show up at the ports within one operation. A wrong sequence state either starts an operation where none should begin, so ready drops on the edge after a write that should have been ignored, or it fails to start one, so the target keeps reading 0xFFFF. A wrong timer shows up as a busy window whose measured length differs from PROG_CYC or from sector-words plus ERASE_CYC. A wrong byte lane, sector base or status field appears on the first read after completion, or on the first status read.

// File: rtl/flash_pkg.sv
// Shared types and command constants for the flash command interface.
// Assumes command codes travel on data bits 7:0 and command addresses
// are compared on an 11-bit word address.
package flash_pkg;

    localparam int CMD_AW = 11;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM,
        SQ_ERA0,
        SQ_ERA1,
        SQ_ERA2,
        SQ_BYP,
        SQ_BPGM,
        SQ_BEXIT
    } seq_state_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_PROG,
        EN_ZERO,
        EN_PULSE
    } eng_state_t;

    localparam logic [7:0] CODE_KEY_A      = 8'hAA;
    localparam logic [7:0] CODE_KEY_B      = 8'h55;
    localparam logic [7:0] CODE_PROGRAM    = 8'hA0;
    localparam logic [7:0] CODE_ERASE_ARM  = 8'h80;
    localparam logic [7:0] CODE_ERASE_SECT = 8'h30;
    localparam logic [7:0] CODE_BYP_ENTER  = 8'h20;
    localparam logic [7:0] CODE_BYP_LEAVE  = 8'h90;
    localparam logic [7:0] CODE_BYP_DONE   = 8'h00;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;

endpackage

// File: rtl/flash_bus_front.sv
// Bus front end: turns the select and strobe inputs into single-cycle
// write and read-start events and decodes the address.
// Assumes strobes are stable for at least one clock cycle. A write is
// taken on the first cycle its strobe is seen low, unless writes are
// blocked by the low-supply input or by a running operation.
module flash_bus_front #(
    parameter int ADDR_W = 12,
    parameter int ARR_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    input  logic              inhibit,
    input  logic              busy,
    output logic              wr_ev,
    output logic              rd_start,
    output logic              rd_active,
    output logic [ADDR_W-2:0] word_addr,
    output logic [ARR_AW-1:0] word_idx,
    output logic              lane
);

    logic wr_q;
    logic rd_q;

    // Remember the previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    // Address decode and event generation.
    always_comb begin
        word_addr = byte_mode ? addr[ADDR_W-1:1] : addr[ADDR_W-2:0];
        word_idx  = word_addr[ARR_AW-1:0];
        lane      = byte_mode & addr[0];
        rd_active = !sel_n && !rd_n;
        rd_start  = rd_active && rd_q;
        wr_ev     = !sel_n && !wr_n && wr_q && !inhibit && !busy;
    end

endmodule

// File: rtl/flash_seq.sv
// Command sequence decoder. Follows the unlock and command writes and
// issues a single-cycle program or erase request on the final write.
// Assumes wr_ev is already blocked during operations. A wrong step drops
// back to read mode, or to bypass mode inside a bypass sub-sequence.
module flash_seq #(
    parameter int SECT_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_ev,
    input  logic [flash_pkg::CMD_AW-1:0] cmd_addr,
    input  logic [7:0]                  wcode,
    input  logic [SECT_W-1:0]           sect,
    input  logic [(1<<SECT_W)-1:0]      sect_lock,
    output logic                        go_prog,
    output logic                        go_erase
);
    import flash_pkg::*;

    seq_state_t st;
    seq_state_t nxt;
    logic       key_a;
    logic       key_b;
    logic       at_a;
    logic       locked;

    // Next-state and request decode for each accepted write.
    always_comb begin
        key_a    = (cmd_addr == KEY_ADDR_A) && (wcode == CODE_KEY_A);
        key_b    = (cmd_addr == KEY_ADDR_B) && (wcode == CODE_KEY_B);
        at_a     = (cmd_addr == KEY_ADDR_A);
        locked   = sect_lock[sect];
        nxt      = st;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        if (wr_ev) begin
            unique case (st)
                SQ_IDLE:  nxt = key_a ? SQ_UNL1 : SQ_IDLE;
                SQ_UNL1:  nxt = key_b ? SQ_UNL2 : SQ_IDLE;
                SQ_UNL2: begin
                    if (at_a && wcode == CODE_PROGRAM)        nxt = SQ_PGM;
                    else if (at_a && wcode == CODE_ERASE_ARM) nxt = SQ_ERA0;
                    else if (at_a && wcode == CODE_BYP_ENTER) nxt = SQ_BYP;
                    else                                      nxt = SQ_IDLE;
                end
                SQ_PGM: begin
                    go_prog = !locked;
                    nxt     = SQ_IDLE;
                end
                SQ_ERA0:  nxt = key_a ? SQ_ERA1 : SQ_IDLE;
                SQ_ERA1:  nxt = key_b ? SQ_ERA2 : SQ_IDLE;
                SQ_ERA2: begin
                    go_erase = (wcode == CODE_ERASE_SECT) && !locked;
                    nxt      = SQ_IDLE;
                end
                SQ_BYP: begin
                    if (wcode == CODE_PROGRAM)        nxt = SQ_BPGM;
                    else if (wcode == CODE_BYP_LEAVE) nxt = SQ_BEXIT;
                    else                              nxt = SQ_BYP;
                end
                SQ_BPGM: begin
                    go_prog = !locked;
                    nxt     = SQ_BYP;
                end
                SQ_BEXIT: nxt = (wcode == CODE_BYP_DONE) ? SQ_IDLE : SQ_BYP;
                default:  nxt = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= nxt;
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && !wr_ev) |=> (st == SQ_IDLE));

endmodule

// File: rtl/flash_engine.sv
// Embedded operation engine and storage array. Runs timed programs and
// two-phase sector erases, and builds read data or status words.
// Assumes a request arrives only while idle. The erase clears the sector
// word by word, then waits ERASE_CYC cycles and fills it with ones.
module flash_engine #(
    parameter int ARR_AW    = 6,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_prog,
    input  logic              go_erase,
    input  logic [ARR_AW-1:0] idx,
    input  logic              lane,
    input  logic              byte_mode,
    input  logic [15:0]       wdata,
    input  logic              rd_active,
    input  logic              rd_start,
    output logic              busy,
    output logic [15:0]       rdata
);
    import flash_pkg::*;

    localparam int WORDS      = 1 << ARR_AW;
    localparam int SECT_AW    = ARR_AW - SECT_W;
    localparam int SECT_WORDS = 1 << SECT_AW;
    localparam int CNT_MAX    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    eng_state_t         st;
    logic [CNT_W-1:0]   cnt;
    logic [ARR_AW-1:0]  p_idx;
    logic [15:0]        p_data;
    logic               p_lane;
    logic               p_byte;
    logic [SECT_W-1:0]  e_sect;
    logic [SECT_AW-1:0] zidx;
    logic               tog;
    logic [15:0]        mem [WORDS];

    assign busy = (st != EN_IDLE);

    // Operation sequencing: latch the request, then count down each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= EN_IDLE;
            cnt    <= '0;
            p_idx  <= '0;
            p_data <= '1;
            p_lane <= 1'b0;
            p_byte <= 1'b0;
            e_sect <= '0;
            zidx   <= '0;
        end else begin
            unique case (st)
                EN_IDLE: begin
                    if (go_prog) begin
                        st     <= EN_PROG;
                        cnt    <= CNT_W'(PROG_CYC - 1);
                        p_idx  <= idx;
                        p_data <= wdata;
                        p_lane <= lane;
                        p_byte <= byte_mode;
                    end else if (go_erase) begin
                        st     <= EN_ZERO;
                        zidx   <= '0;
                        e_sect <= idx[ARR_AW-1 -: SECT_W];
                        p_data <= '1;
                    end
                end
                EN_PROG, EN_PULSE: begin
                    if (cnt == '0) st <= EN_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                EN_ZERO: begin
                    if (zidx == SECT_AW'(SECT_WORDS - 1)) begin
                        st  <= EN_PULSE;
                        cnt <= CNT_W'(ERASE_CYC - 1);
                    end else begin
                        zidx <= zidx + 1'b1;
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // Array updates: program commit, per-word clear, whole-sector fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < WORDS; j++) mem[j] <= '1;
        end else begin
            if (st == EN_PROG && cnt == '0) begin
                if (!p_byte)    mem[p_idx]       <= p_data;
                else if (p_lane) mem[p_idx][15:8] <= p_data[7:0];
                else            mem[p_idx][7:0]  <= p_data[7:0];
            end
            if (st == EN_ZERO) mem[{e_sect, zidx}] <= '0;
            if (st == EN_PULSE && cnt == '0) begin
                for (int j = 0; j < WORDS; j++)
                    if ((j >> SECT_AW) == int'(e_sect)) mem[j] <= '1;
            end
        end
    end

    // Status toggle bit: flips on every read access during an operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                tog <= 1'b0;
        else if (rd_start && busy) tog <= ~tog;
    end

    // Read path: status while busy, otherwise array word or byte lane.
    always_comb begin
        if (!rd_active)    rdata = '0;
        else if (busy)     rdata = {8'h00, ~p_data[7], tog, 6'b0};
        else if (byte_mode) rdata = lane ? {8'h00, mem[idx][15:8]}
                                         : {8'h00, mem[idx][7:0]};
        else               rdata = mem[idx];
    end

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_prog || go_erase) |=> busy);

endmodule

// File: rtl/flash_cmd_core.sv
// Top level of the NOR flash command interface. Connects the bus front
// end, the sequence decoder and the operation engine.
// Assumes ADDR_W is 12 so the word address holds the 11-bit command
// address, and that the array has 2**ARR_AW words in 2**SECT_W sectors.
module flash_cmd_core #(
    parameter int ADDR_W    = 12,
    parameter int ARR_AW    = 6,
    parameter int SECT_W    = 2,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel_n,
    input  logic                   bus_wr_n,
    input  logic                   bus_rd_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    input  logic                   byte_mode,
    input  logic                   supply_low,
    input  logic [(1<<SECT_W)-1:0] sect_lock,
    output logic                   ready
);
    import flash_pkg::*;

    logic              wr_ev;
    logic              rd_start;
    logic              rd_active;
    logic [ADDR_W-2:0] word_addr;
    logic [ARR_AW-1:0] word_idx;
    logic              lane;
    logic              busy;
    logic              go_prog;
    logic              go_erase;
    logic [SECT_W-1:0] sect;

    assign sect  = word_idx[ARR_AW-1 -: SECT_W];
    assign ready = !busy;

    flash_bus_front #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) front_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (bus_sel_n),
        .wr_n      (bus_wr_n),
        .rd_n      (bus_rd_n),
        .addr      (bus_addr),
        .byte_mode (byte_mode),
        .inhibit   (supply_low),
        .busy      (busy),
        .wr_ev     (wr_ev),
        .rd_start  (rd_start),
        .rd_active (rd_active),
        .word_addr (word_addr),
        .word_idx  (word_idx),
        .lane      (lane)
    );

    flash_seq #(.SECT_W(SECT_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (wr_ev),
        .cmd_addr  (word_addr[CMD_AW-1:0]),
        .wcode     (bus_wdata[7:0]),
        .sect      (sect),
        .sect_lock (sect_lock),
        .go_prog   (go_prog),
        .go_erase  (go_erase)
    );

    flash_engine #(
        .ARR_AW    (ARR_AW),
        .SECT_W    (SECT_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_prog   (go_prog),
        .go_erase  (go_erase),
        .idx       (word_idx),
        .lane      (lane),
        .byte_mode (byte_mode),
        .wdata     (bus_wdata),
        .rd_active (rd_active),
        .rd_start  (rd_start),
        .busy      (busy),
        .rdata     (bus_rdata)
    );

    // R10
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> !(go_prog || go_erase));

    // R12
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(go_prog || go_erase));

    // R9
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_prog || go_erase) |-> !sect_lock[sect]);

endmodule

// File: tb/flash_cmd_core_tb_top.sv
// Self-checking bench for flash_cmd_core: a vector table of program and
// read-back pairs, then directed tests for each requirement.
module flash_cmd_core_tb_top;

    localparam int P_PROG  = 8;
    localparam int P_ERASE = 20;
    localparam int SW      = 16;
    localparam int NVEC    = 6;

    // {word address, data} pairs, each in its own word
    localparam logic [27:0] VEC [NVEC] = '{
        {12'h003, 16'hA5C3},
        {12'h010, 16'h1357},
        {12'h01F, 16'hFACE},
        {12'h02A, 16'h0F0F},
        {12'h031, 16'hC0DE},
        {12'h000, 16'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel_n, bus_wr_n, bus_rd_n;
    logic [11:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        byte_mode, supply_low;
    logic [3:0]  sect_lock;
    logic        ready;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [11:0] ca = 12'h555;
    logic [11:0] cb = 12'h2AA;

    always #5 clk = ~clk;

    flash_cmd_core #(.PROG_CYC(P_PROG), .ERASE_CYC(P_ERASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .byte_mode(byte_mode), .supply_low(supply_low),
        .sect_lock(sect_lock), .ready(ready)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_cyc(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        @(negedge clk);
        bus_wr_n = 1'b1; bus_sel_n = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_sel_n = 1'b0; bus_rd_n = 1'b0;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd_n = 1'b1; bus_sel_n = 1'b1;
    endtask

    task automatic unlock();
        wr_cyc(ca, 16'h00AA);
        wr_cyc(cb, 16'h0055);
    endtask

    task automatic prog(input logic [11:0] a, input logic [15:0] d);
        unlock();
        wr_cyc(ca, 16'h00A0);
        wr_cyc(a, d);
    endtask

    task automatic erase(input logic [11:0] a);
        unlock();
        wr_cyc(ca, 16'h0080);
        unlock();
        wr_cyc(a, 16'h0030);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v, s1, s2;
        int n;
        rst_n = 1'b0; bus_sel_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
        bus_addr = '0; bus_wdata = '0; byte_mode = 1'b0; supply_low = 1'b0;
        sect_lock = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 ready after reset", {15'b0, ready}, 16'h0001);
        rd(12'h000, v); check("R1 word 0 erased", v, 16'hFFFF);
        rd(12'h03F, v); check("R1 last word erased", v, 16'hFFFF);

        // R2 vector table: program then read back
        for (int i = 0; i < NVEC; i++) begin
            prog(VEC[i][27:16], VEC[i][15:0]);
            measure(n);
            rd(VEC[i][27:16], v);
            check("R2 program read-back", v, VEC[i][15:0]);
        end

        // R3 busy window length
        prog(12'h005, 16'h00AA);
        measure(n);
        check("R3 program busy cycles", 16'(n), 16'(P_PROG));
        rd(12'h005, v); check("R3 data after busy", v, 16'h00AA);

        // R4 status reads during program
        prog(12'h006, 16'h0055);
        rd(12'h000, s1);
        rd(12'h000, s2);
        check("R4 status first", s1 & 16'hFFBF, 16'h0080);
        check("R4 status second", s2 & 16'hFFBF, 16'h0080);
        check("R4 toggle differs", {15'b0, s1[6] ^ s2[6]}, 16'h0001);
        measure(n);
        rd(12'h006, v); check("R4 array read resumes", v, 16'h0055);

        // R5 byte mode program to high lane of word 0x21
        byte_mode = 1'b1; ca = 12'hAAA; cb = 12'h554;
        prog(12'h043, 16'h003C);
        measure(n);
        rd(12'h043, v); check("R5 high byte", v, 16'h003C);
        rd(12'h042, v); check("R5 low byte untouched", v, 16'h00FF);
        byte_mode = 1'b0; ca = 12'h555; cb = 12'h2AA;
        rd(12'h021, v); check("R5 word view", v, 16'h3CFF);

        // R6 unlock bypass
        unlock(); wr_cyc(ca, 16'h0020);
        wr_cyc(12'h000, 16'h00A0); wr_cyc(12'h022, 16'h1234);
        measure(n);
        rd(12'h022, v); check("R6 bypass program", v, 16'h1234);
        wr_cyc(12'h000, 16'h0077);
        wr_cyc(12'h000, 16'h00A0); wr_cyc(12'h023, 16'h0BAD);
        measure(n);
        rd(12'h023, v); check("R6 stray write ignored in bypass", v, 16'h0BAD);
        wr_cyc(12'h000, 16'h0090); wr_cyc(12'h000, 16'h0000);
        wr_cyc(12'h000, 16'h00A0); wr_cyc(12'h024, 16'h5678);
        check("R6 no busy after exit", {15'b0, ready}, 16'h0001);
        rd(12'h024, v); check("R6 two-write program after exit", v, 16'hFFFF);

        // R10 supply inhibit
        supply_low = 1'b1;
        prog(12'h025, 16'h4444);
        check("R10 ready during inhibit", {15'b0, ready}, 16'h0001);
        supply_low = 1'b0;
        rd(12'h025, v); check("R10 inhibited program", v, 16'hFFFF);

        // R11 out-of-sequence abort and 0xF0
        wr_cyc(ca, 16'h00AA); wr_cyc(cb, 16'h0012);
        wr_cyc(cb, 16'h0055); wr_cyc(ca, 16'h00A0); wr_cyc(12'h026, 16'h2222);
        rd(12'h026, v); check("R11 aborted sequence", v, 16'hFFFF);
        unlock(); wr_cyc(ca, 16'h00F0);
        wr_cyc(ca, 16'h00A0); wr_cyc(12'h026, 16'h3333);
        rd(12'h026, v); check("R11 reset code aborts", v, 16'hFFFF);

        // R12 writes while busy
        prog(12'h027, 16'h1111);
        prog(12'h028, 16'h9999);
        measure(n);
        rd(12'h027, v); check("R12 first program", v, 16'h1111);
        rd(12'h028, v); check("R12 busy writes ignored", v, 16'hFFFF);

        // R7 R8 sector erase of sector 1
        erase(12'h012);
        measure(n);
        check("R7 R8 erase busy cycles", 16'(n), 16'(SW + P_ERASE));
        rd(12'h010, v); check("R7 sector word erased", v, 16'hFFFF);
        rd(12'h01F, v); check("R7 sector end erased", v, 16'hFFFF);
        rd(12'h003, v); check("R7 other sector kept", v, 16'hA5C3);
        rd(12'h02A, v); check("R7 next sector kept", v, 16'h0F0F);

        // R7 status during erase of sector 2
        erase(12'h020);
        rd(12'h000, s1);
        check("R7 erase poll bit", s1 & 16'hFFBF, 16'h0000);
        measure(n);
        rd(12'h02A, v); check("R7 sector 2 erased", v, 16'hFFFF);

        // R9 locked sector 3
        sect_lock = 4'b1000;
        prog(12'h032, 16'h7777);
        check("R9 no busy on locked program", {15'b0, ready}, 16'h0001);
        rd(12'h032, v); check("R9 locked program", v, 16'hFFFF);
        erase(12'h030);
        check("R9 no busy on locked erase", {15'b0, ready}, 16'h0001);
        rd(12'h031, v); check("R9 locked erase", v, 16'hC0DE);

        summary();
        $finish;
    end

endmodule